// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared single-transaction-per-cycle bus. The cache is direct-mapped, holds one data word per line, and tags every line as Invalid, Shared or Modified. Writes are kept locally and reach memory only on eviction or when another cache asks for the line. A write first invalidates all other copies.

The processor side takes a request held with constant address, direction and write data until `pr_ready` pulses. A hit answers at once. A miss stalls while the controller raises `bus_req`, waits for `bus_gnt`, and fills the line. The bus side sees every transaction that other controllers issue. When this cache owns the only current copy of the requested line, it answers in the same cycle on `flush` and `flush_data`. An external arbiter and memory model complete the bus.

A bus transaction lasts exactly one granted cycle. The command codes are 0 for idle, 1 for shared read, 2 for exclusive read and 3 for write-back. The line index is the low `$clog2(LINES)` address bits, and the tag is the remaining upper bits.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid: no bus request and no flush is driven, and the first access to any address misses.
- R2: A read that misses issues one shared-read transaction (code 1) for the address, returns the fill data, and leaves the line Shared.
- R3: A write to an Invalid line, or to a line held Shared, issues one exclusive-read transaction (code 2) and leaves the line Modified holding the written word.
- R4: Reads that hit a Shared or Modified line, and writes that hit a Modified line, complete with no bus transaction.
- R5: A Shared line whose address is seen in another agent's exclusive read becomes Invalid.
- R6: A Modified line whose address is seen in another agent's shared read asserts `flush` with its data in that cycle and becomes Shared, still readable locally.
- R7: A Modified line whose address is seen in another agent's exclusive read asserts `flush` with its data in that cycle and becomes Invalid.
- R8: A miss that displaces a Modified line first issues a write-back transaction (code 3) with the old address and data, and only then issues the request for the new block.
- R9: A miss that displaces a Shared line issues no write-back.
- R10: In a cycle where a snooped transaction is present, the processor request is not answered, even when it would hit. It is answered in a later cycle.
- R11: A snooped transaction whose tag differs from the stored tag, or that targets an Invalid line, drives no flush and leaves the line's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pr_req | input | 1 | Processor request, held until answered |
| pr_we | input | 1 | 1 for write, 0 for read |
| pr_addr | input | ADDR_W | Processor word address |
| pr_wdata | input | DATA_W | Processor write data |
| pr_ready | output | 1 | Request answered this cycle |
| pr_rdata | output | DATA_W | Read data, valid with pr_ready |
| bus_req | output | 1 | Request to drive the bus |
| bus_gnt | input | 1 | Bus granted; the transaction happens this cycle |
| bus_cmd | output | 2 | Own command: 0 idle, 1 shared read, 2 exclusive read, 3 write-back |
| bus_addr | output | ADDR_W | Own transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data for the own transaction |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same codes as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| flush | output | 1 | This cache supplies the snooped line |
| flush_data | output | DATA_W | Supplied line data |

## Verification
Several state changes are checked by assertions on every cycle: a shared fill lands in Shared, an own write lands in Modified with the written word, a snooped exclusive read that matches invalidates the line, and a flush on a shared read leaves Shared. They also check that a write-back leaves the victim Invalid before the new request, that hits never raise the bus, and that non-matching snoops keep the state. Only the two-cache bench scenarios can show the system-level results. These include data travelling from one cache to the other through a flush, dirty data reaching memory through eviction, upgrades from Shared costing exactly one transaction, and a hitting request held off for one cycle by a concurrent snoop.

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pr_req,
  input  logic              pr_we,
  input  logic [ADDR_W-1:0] pr_addr,
  input  logic [DATA_W-1:0] pr_wdata,
  output logic              pr_ready,
  output logic [DATA_W-1:0] pr_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush,
  output logic [DATA_W-1:0] flush_data
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3;
  localparam logic [1:0] F_IDLE = 2'd0, F_WB = 2'd1, F_REQ = 2'd2;

  logic [1:0]        st  [LINES];
  logic [TAG_W-1:0]  tg  [LINES];
  logic [DATA_W-1:0] dat [LINES];
  logic [1:0]        fsm;

  logic [IDX_W-1:0] pidx, sidx;
  logic [TAG_W-1:0] ptag, stag;
  logic p_hit, victim_dirty, snp_hit;

  assign pidx = pr_addr[IDX_W-1:0];
  assign ptag = pr_addr[ADDR_W-1:IDX_W];
  assign sidx = snp_addr[IDX_W-1:0];
  assign stag = snp_addr[ADDR_W-1:IDX_W];

  assign p_hit = (st[pidx] != ST_I) && (tg[pidx] == ptag) && (!pr_we || st[pidx] == ST_M);
  assign victim_dirty = (st[pidx] == ST_M) && (tg[pidx] != ptag);

  assign pr_ready = pr_req && (fsm == F_IDLE) && !snp_valid && p_hit;
  assign pr_rdata = dat[pidx];

  assign snp_hit = snp_valid && (snp_cmd == CMD_RD || snp_cmd == CMD_RDX) &&
                   (st[sidx] != ST_I) && (tg[sidx] == stag);
  assign flush      = snp_hit && (st[sidx] == ST_M);
  assign flush_data = dat[sidx];

  assign bus_req   = (fsm == F_WB && st[pidx] == ST_M) || (fsm == F_REQ);
  assign bus_cmd   = (fsm == F_WB) ? CMD_WB : (fsm == F_REQ) ? (pr_we ? CMD_RDX : CMD_RD) : CMD_NONE;
  assign bus_addr  = (fsm == F_WB) ? {tg[pidx], pidx} : pr_addr;
  assign bus_wdata = dat[pidx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm <= F_IDLE;
      for (int i = 0; i < LINES; i++) st[i] <= ST_I;
    end else begin
      if (snp_hit) st[sidx] <= (snp_cmd == CMD_RD) ? ST_S : ST_I;
      case (fsm)
        F_IDLE: begin
          if (pr_req && !snp_valid && !p_hit) fsm <= victim_dirty ? F_WB : F_REQ;
          else if (pr_ready && pr_we) dat[pidx] <= pr_wdata;
        end
        F_WB: begin
          if (st[pidx] != ST_M) fsm <= F_REQ;
          else if (bus_gnt) begin
            st[pidx] <= ST_I;
            fsm      <= F_REQ;
          end
        end
        F_REQ: begin
          if (bus_gnt) begin
            tg[pidx]  <= ptag;
            st[pidx]  <= pr_we ? ST_M : ST_S;
            dat[pidx] <= pr_we ? pr_wdata : bus_rdata;
            fsm       <= F_IDLE;
          end
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end

  AST_RD_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt && bus_cmd == CMD_RD |=> st[$past(pidx)] == ST_S); // R2
  AST_WRITE_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_ready && pr_we) || (bus_gnt && bus_cmd == CMD_RDX)
    |=> st[$past(pidx)] == ST_M && dat[$past(pidx)] == $past(pr_wdata)); // R3
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pr_ready |-> !bus_req); // R4
  AST_SNP_RDX_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit && snp_cmd == CMD_RDX |=> st[$past(sidx)] == ST_I); // R5
  AST_FLUSH_TO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    flush && snp_cmd == CMD_RD |=> st[$past(sidx)] == ST_S); // R6
  AST_FLUSH_RDX_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
    flush && snp_cmd == CMD_RDX |=> st[$past(sidx)] == ST_I); // R7
  AST_WB_THEN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt && bus_cmd == CMD_WB |=> st[$past(pidx)] == ST_I && bus_cmd != CMD_WB); // R8
  AST_SNP_MISS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_hit && fsm == F_IDLE |=> st[$past(sidx)] == $past(st[sidx])); // R11
endmodule

// File: tb/msi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        preq [2], pwe [2], prdy [2], breq [2], gnt [2], fl [2];
  logic [15:0] paddr [2], baddr [2];
  logic [31:0] pwd [2], prd [2], bwd [2], brd [2], fd [2];
  logic [1:0]  bcmd [2];
  logic [31:0] mem [256];
  int txc [2], flc [2];
  int tests = 0, fails = 0;
  bit done = 0;

  assign gnt[0] = breq[0];
  assign gnt[1] = breq[1] && !breq[0];
  assign brd[0] = fl[1] ? fd[1] : mem[baddr[0][7:0]];
  assign brd[1] = fl[0] ? fd[0] : mem[baddr[1][7:0]];

  msi_snoop_ctrl u_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .pr_req(preq[0]), .pr_we(pwe[0]), .pr_addr(paddr[0]),
    .pr_wdata(pwd[0]), .pr_ready(prdy[0]), .pr_rdata(prd[0]), .bus_req(breq[0]),
    .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]), .bus_wdata(bwd[0]),
    .bus_rdata(brd[0]), .snp_valid(gnt[1]), .snp_cmd(bcmd[1]), .snp_addr(baddr[1]),
    .flush(fl[0]), .flush_data(fd[0]));

  msi_snoop_ctrl u_msi_snoop_ctrl_b (
    .clk(clk), .rst_n(rst_n), .pr_req(preq[1]), .pr_we(pwe[1]), .pr_addr(paddr[1]),
    .pr_wdata(pwd[1]), .pr_ready(prdy[1]), .pr_rdata(prd[1]), .bus_req(breq[1]),
    .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]), .bus_wdata(bwd[1]),
    .bus_rdata(brd[1]), .snp_valid(gnt[0]), .snp_cmd(bcmd[0]), .snp_addr(baddr[0]),
    .flush(fl[1]), .flush_data(fd[1]));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA000_0000 + i;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (gnt[c]) txc[c] = txc[c] + 1;
        if (fl[c]) flc[c] = flc[c] + 1;
        if (gnt[c] && bcmd[c] == 2'd3) mem[baddr[c][7:0]] <= bwd[c];
        if (fl[c]) mem[baddr[1-c][7:0]] <= fd[c];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input int c, input bit we, input logic [15:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int txn, output int fln);
    int t0 = txc[c];
    int f0 = flc[1-c];
    bit got = 0;
    rd = '0;
    preq[c] = 1'b1; pwe[c] = we; paddr[c] = a; pwd[c] = wd;
    for (int k = 0; k < 40 && !got; k++) begin
      #1;
      if (prdy[c]) begin got = 1; rd = prd[c]; end
      else @(negedge clk);
    end
    @(negedge clk);
    preq[c] = 1'b0; pwe[c] = 1'b0;
    if (!got) chk("R4 request never answered", 32'd0, 32'd1);
    txn = txc[c] - t0;
    fln = flc[1-c] - f0;
  endtask

  logic [31:0] rd;
  int txn, fln;

  task automatic t_reset();
    #1;
    chk("R1 no bus request after reset", {31'd0, breq[0]}, 32'd0);
    chk("R1 no flush after reset", {31'd0, fl[0] | fl[1]}, 32'd0);
    @(negedge clk);
  endtask

  task automatic t_read_share();
    access(0, 0, 16'h0010, 0, rd, txn, fln);
    chk("R1 R2 first read misses once", txn, 1);
    chk("R2 read miss data", rd, 32'hA000_0010);
    access(0, 0, 16'h0010, 0, rd, txn, fln);
    chk("R4 read hit in S no traffic", txn, 0);
    access(1, 0, 16'h0010, 0, rd, txn, fln);
    chk("R2 second cache read miss", txn, 1);
    chk("R11 shared holder does not flush", fln, 0);
  endtask

  task automatic t_write_flush();
    access(0, 1, 16'h0010, 32'h1111, rd, txn, fln);
    chk("R3 upgrade from S is one transaction", txn, 1);
    access(1, 0, 16'h0010, 0, rd, txn, fln);
    chk("R5 invalidated S copy misses", txn, 1);
    chk("R6 owner flushes on shared read", fln, 1);
    chk("R6 flushed data reaches reader", rd, 32'h1111);
    access(0, 0, 16'h0010, 0, rd, txn, fln);
    chk("R6 flushed owner still hits", txn, 0);
    chk("R6 flushed owner data", rd, 32'h1111);
    access(0, 1, 16'h0010, 32'h2222, rd, txn, fln);
    chk("R3 write to S after flush upgrades", txn, 1);
    access(0, 1, 16'h0010, 32'h2525, rd, txn, fln);
    chk("R4 write hit in M no traffic", txn, 0);
  endtask

  task automatic t_rdx_flush();
    access(1, 1, 16'h0010, 32'h3333, rd, txn, fln);
    chk("R3 write miss one transaction", txn, 1);
    chk("R7 owner flushes on exclusive read", fln, 1);
    access(0, 0, 16'h0010, 0, rd, txn, fln);
    chk("R7 old owner invalidated", txn, 1);
    chk("R7 R6 new owner supplies data", rd, 32'h3333);
  endtask

  task automatic t_evict();
    access(1, 1, 16'h0018, 32'h4444, rd, txn, fln);
    chk("R9 shared victim evicted silently", txn, 1);
    access(1, 0, 16'h0020, 0, rd, txn, fln);
    chk("R8 dirty victim write-back plus read", txn, 2);
    chk("R8 new block data", rd, 32'hA000_0020);
    access(0, 0, 16'h0018, 0, rd, txn, fln);
    chk("R8 written-back data in memory", rd, 32'h4444);
    chk("R8 no flush after write-back", fln, 0);
  endtask

  task automatic t_tag_mismatch();
    access(0, 1, 16'h0028, 32'h5555, rd, txn, fln);
    chk("R11 mismatched tag no flush", fln, 0);
    access(1, 0, 16'h0020, 0, rd, txn, fln);
    chk("R11 mismatched snoop keeps S line", txn, 0);
    chk("R11 kept line data", rd, 32'hA000_0020);
  endtask

  task automatic t_snoop_priority();
    bit seen = 0;
    preq[0] = 1'b1; pwe[0] = 1'b0; paddr[0] = 16'h0001;
    for (int k = 0; k < 10 && !seen; k++) begin
      #1;
      if (gnt[0]) seen = 1;
      else @(negedge clk);
    end
    chk("R10 bus granted for miss", {31'd0, seen}, 32'd1);
    chk("R11 invalid line no flush", {31'd0, fl[1]}, 32'd0);
    preq[1] = 1'b1; pwe[1] = 1'b0; paddr[1] = 16'h0020;
    #1;
    chk("R10 hit held off during snoop", {31'd0, prdy[1]}, 32'd0);
    @(negedge clk); #1;
    chk("R10 hit answered after snoop", {31'd0, prdy[1]}, 32'd1);
    chk("R10 hit data", prd[1], 32'hA000_0020);
    chk("R2 filled line answers", prd[0], 32'hA000_0001);
    @(negedge clk);
    preq[0] = 1'b0; preq[1] = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      preq[c] = 0; pwe[c] = 0; paddr[c] = 0; pwd[c] = 0; txc[c] = 0; flc[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_share();
    t_write_flush();
    t_rdx_flush();
    t_evict();
    t_tag_mismatch();
    t_snoop_priority();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule